// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator with Burst Window

This block produces the running phase of a colour subcarrier for an analogue television encoder. A 32-bit phase accumulator is advanced by a programmable frequency step on every cycle in which the pixel clock enable is high. The upper bits of the accumulator are presented as a phase word, which a downstream sine lookup turns into the carrier. Software loads the step as eight 4-bit slices into a staging copy. The step in use changes only when the slice at the highest slice address is written, so a half-written step never reaches the accumulator.

The block also produces a burst-enable window for each line. A rising edge on the horizontal sync input starts a programmable delay, counted in pixel clocks. The window then opens and stays open for a fixed number of subcarrier cycles: 9 for the 525-line standard and 10 for the 625-line standard. One subcarrier cycle is one wrap of the accumulator. In frame-locked mode, a frame-start pulse clears the accumulator so that every frame begins at the same carrier phase. The upper 24 bits of the step in use can be read back one byte at a time.

Top module: `subcarrier_gen`

## Requirements
- R1: After reset the phase word is 0, burst_en is 0, and every read-back selection returns 0.
- R2: A write with wr_addr = k (k = 0..7) places wr_data into bits [4k+3:4k] of the staging copy. Writes to addresses 0 to 6 leave the step in use, and its read-back, unchanged.
- R3: A write to address 7 makes the step in use equal to the staging copy with wr_data merged into bits [31:28]. The change takes effect in the next cycle.
- R4: At each clock edge with pix_en high, the accumulator becomes (accumulator + step) mod 2^32. With pix_en low it holds. phase_out is accumulator bits [31:22].
- R5: rd_sel = 0, 1 and 2 return bits [15:8], [23:16] and [31:24] of the step in use. rd_sel = 3 returns 0. The read-back is combinational.
- R6: If hsync is sampled low at one edge and high at the next edge E, burst_en is 0 after E. With pix_en held high, it rises after edge E+D+1, where D is burst_dly.
- R7: Once open, the window counts accumulator wraps. It closes at the edge that follows the N-th counted wrap, where N = 9 when std_pal = 0 and N = 10 when std_pal = 1.
- R8: When frame_lock and frame_sof are both high at an edge, the accumulator becomes 0 and no wrap is produced. With frame_lock low, frame_sof has no effect.
- R9: A new rising hsync edge while the window is open or waiting closes the window and restarts the delay.
- R10: Accumulator wraps that occur while the delay is still running are not counted toward N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable |
| wr_en | input | 1 | Step slice write strobe |
| wr_addr | input | 3 | Slice index, 7 commits |
| wr_data | input | 4 | Slice value |
| rd_sel | input | 2 | Read-back byte select |
| rd_data | output | 8 | Selected byte of the step in use |
| std_pal | input | 1 | 0: 9-cycle burst, 1: 10-cycle burst |
| burst_dly | input | 8 | Pixel clocks from sync edge to burst start |
| hsync | input | 1 | Horizontal sync, rising edge active |
| frame_lock | input | 1 | Enables phase clear at frame start |
| frame_sof | input | 1 | Frame start pulse |
| phase_out | output | 10 | Upper accumulator bits |
| burst_en | output | 1 | Burst window |

## Verification
Two pairs of events can land on the same edge. The first pair is a frame-start clear and a rising sync edge. Every burst run in the sweep raises both together, so the delay count and the wrap count start from an accumulator known to be zero. The bench then judges each cycle's phase word and window level against arithmetic on multiples of the step. The second pair is a frame-start clear and the commit of a new step. The bench expects phase zero after that edge and exactly one new step after the following edge.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {BG_IDLE, BG_WAIT, BG_OPEN} bg_state_e;
  localparam int unsigned CYC_525 = 9;
  localparam int unsigned CYC_625 = 10;
  localparam int unsigned CYC_MAX = (CYC_625 > CYC_525) ? CYC_625 : CYC_525;
  localparam int unsigned CYC_W   = $clog2(CYC_MAX + 1);
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sc_step_loader.sv
module sc_step_loader #(
  parameter int unsigned SLICE_W  = 4,
  parameter int unsigned N_SLICES = 8,
  parameter int unsigned RB_BYTES = 3,
  localparam int unsigned ACC_W  = SLICE_W * N_SLICES,
  localparam int unsigned ADDR_W = $clog2(N_SLICES),
  localparam int unsigned SEL_W  = $clog2(RB_BYTES + 1),
  localparam int unsigned RB_LO  = ACC_W - 8 * RB_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [7:0]        rd_data,
  output logic [ACC_W-1:0]  step_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_SLICES - 1);

  logic [ACC_W-1:0] stage_q, stage_d;
  logic [ACC_W-1:0] step_q, step_d;
  logic             commit;
  logic [7:0]       rb_byte [RB_BYTES];

  assign commit = wr_en && (wr_addr == LAST_ADDR);

  always_comb begin
    stage_d = stage_q;
    if (wr_en) begin
      for (int k = 0; k < N_SLICES; k++) begin
        if (wr_addr == ADDR_W'(k)) stage_d[k*SLICE_W +: SLICE_W] = wr_data;
      end
    end
    step_d = step_q;
    if (commit) step_d = stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      step_q  <= '0;
    end else begin
      if (wr_en)  stage_q <= stage_d;
      if (commit) step_q  <= step_d;
    end
  end

  for (genvar b = 0; b < RB_BYTES; b++) begin : g_rb
    assign rb_byte[b] = step_q[RB_LO + 8*b +: 8];
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < RB_BYTES; b++) begin
      if (rd_sel == SEL_W'(b)) rd_data = rb_byte[b];
    end
  end

  assign step_o = step_q;

  // R2
  no_early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == LAST_ADDR) |=> $stable(step_o));
endmodule

// File: rtl/sc_phase_accum.sv
module sc_phase_accum #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PH_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             wrap_q, wrap_d;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step_i};

  always_comb begin
    acc_d  = acc_q;
    wrap_d = 1'b0;
    if (clr_i) begin
      acc_d = '0;
    end else if (pix_en) begin
      acc_d  = sum[ACC_W-1:0];
      wrap_d = sum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      wrap_q <= wrap_d;
    end
  end

  assign phase_o = acc_q[ACC_W-1 -: PH_W];
  assign wrap_o  = wrap_q;

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !clr_i) |=> ($stable(acc_q) && !wrap_o));

  // R8
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_o == '0 && !wrap_o));
endmodule

// File: rtl/sc_burst_gate.sv
module sc_burst_gate
  import sc_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             hsync,
  input  logic             wrap_i,
  input  logic             pal_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             burst_o
);
  bg_state_e        st_q, st_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [CYC_W-1:0] target;
  logic             hs_q;
  logic             hs_rise;

  assign hs_rise = hsync && !hs_q;
  assign target  = pal_i ? CYC_W'(CYC_625) : CYC_W'(CYC_525);

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    cyc_d = cyc_q;
    unique case (st_q)
      BG_WAIT: begin
        if (pix_en) begin
          if (dly_q == '0) begin
            st_d  = BG_OPEN;
            cyc_d = '0;
          end else begin
            dly_d = dly_q - 1'b1;
          end
        end
      end
      BG_OPEN: begin
        if (wrap_i) begin
          if (cyc_q >= target - 1'b1) st_d = BG_IDLE;
          else                        cyc_d = cyc_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (hs_rise) begin
      st_d  = BG_WAIT;
      dly_d = dly_i;
      cyc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BG_IDLE;
      dly_q <= '0;
      cyc_q <= '0;
      hs_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
      cyc_q <= cyc_d;
      hs_q  <= hsync;
    end
  end

  assign burst_o = (st_q == BG_OPEN);

  // R6
  sync_edge_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> !burst_o);

  // R7
  close_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_o) |-> ($past(wrap_i) || $past(hs_rise)));

  // R6
  open_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_o) |-> ($past(st_q == BG_WAIT) && $past(dly_q == '0) && $past(pix_en)));

  // R7
  cycle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q < CYC_W'(CYC_MAX));
endmodule

// File: rtl/subcarrier_gen.sv
module subcarrier_gen #(
  parameter int unsigned SLICE_W  = 4,
  parameter int unsigned N_SLICES = 8,
  parameter int unsigned PH_W     = 10,
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned RB_BYTES = 3,
  localparam int unsigned ACC_W  = SLICE_W * N_SLICES,
  localparam int unsigned ADDR_W = $clog2(N_SLICES),
  localparam int unsigned SEL_W  = $clog2(RB_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [7:0]         rd_data,
  input  logic               std_pal,
  input  logic [DLY_W-1:0]   burst_dly,
  input  logic               hsync,
  input  logic               frame_lock,
  input  logic               frame_sof,
  output logic [PH_W-1:0]    phase_out,
  output logic               burst_en
);
  logic             rst_n_s;
  logic [ACC_W-1:0] step;
  logic             wrap;
  logic             clr;

  assign clr = frame_lock && frame_sof;

  sc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  sc_step_loader #(
    .SLICE_W  (SLICE_W),
    .N_SLICES (N_SLICES),
    .RB_BYTES (RB_BYTES)
  ) u_load (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .step_o  (step)
  );

  sc_phase_accum #(
    .ACC_W (ACC_W),
    .PH_W  (PH_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pix_en  (pix_en),
    .clr_i   (clr),
    .step_i  (step),
    .phase_o (phase_out),
    .wrap_o  (wrap)
  );

  sc_burst_gate #(
    .DLY_W (DLY_W)
  ) u_burst (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pix_en  (pix_en),
    .hsync   (hsync),
    .wrap_i  (wrap),
    .pal_i   (std_pal),
    .dly_i   (burst_dly),
    .burst_o (burst_en)
  );
endmodule

// File: tb/sim_subcarrier_gen.sv
`timescale 1ns/1ps
module sim_subcarrier_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       std_pal = 1'b0;
  logic [7:0] burst_dly = '0;
  logic       hsync = 1'b0;
  logic       frame_lock = 1'b0;
  logic       frame_sof = 1'b0;
  logic [9:0] phase_out;
  logic       burst_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  subcarrier_gen u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .std_pal(std_pal), .burst_dly(burst_dly), .hsync(hsync),
    .frame_lock(frame_lock), .frame_sof(frame_sof),
    .phase_out(phase_out), .burst_en(burst_en)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] ph_of(longint unsigned m, logic [31:0] st);
    longint unsigned a = (m * st) & 64'hFFFF_FFFF;
    return a[31:22];
  endfunction

  function automatic bit wraps_at(longint unsigned k, logic [31:0] st);
    return ((k * st) >> 32) != (((k - 1) * st) >> 32);
  endfunction

  task automatic post_edge();
    @(posedge clk); #1;
  endtask

  task automatic write_slice(int k, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(k); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_step(logic [31:0] v);
    for (int k = 0; k < 8; k++) write_slice(k, v[4*k +: 4]);
  endtask

  task automatic check_rb(string req, logic [31:0] v);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #0.1;
      check(req, rd_data, (s == 3) ? 0 : v[8 + 8*s +: 8]);
    end
  endtask

  // Clear and sync edge on the same edge, then judge every cycle (R4 R6 R7 R10)
  task automatic burst_run(int d, bit pal, logic [31:0] st);
    int n = pal ? 10 : 9;
    int seen = 0;
    longint unsigned kn = 0;
    load_step(st);
    for (longint unsigned k = longint'(d) + 1; seen < n; k++) begin
      if (wraps_at(k, st)) begin seen++; kn = k; end
    end
    @(negedge clk);
    pix_en = 1'b1; std_pal = pal; burst_dly = 8'(d);
    frame_lock = 1'b1; frame_sof = 1'b1; hsync = 1'b1;
    for (longint unsigned m = 0; m <= kn + 3; m++) begin
      post_edge();
      check(m <= longint'(d) ? "R6" : "R7 R10", burst_en,
            (m >= longint'(d) + 1 && m <= kn) ? 1 : 0);
      check("R4", phase_out, ph_of(m, st));
      @(negedge clk);
      frame_sof = 1'b0;
    end
    hsync = 1'b0; frame_lock = 1'b0;
  endtask

  task automatic run_all();
    logic [31:0] a_val = 32'h1234_5678;
    logic [31:0] b_val = 32'h9ABC_DEF0;
    logic [15:0] pat = 16'b1011_0011_1000_1101;
    int ups = 0;
    logic [9:0] p0;
    int dl [4] = '{0, 1, 3, 10};
    logic [31:0] sl [4] = '{32'h4000_0000, 32'd763366524, 32'h8000_0000, 32'hFFFF_FFFF};

    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check("R1", phase_out, 0);
    check("R1", burst_en, 0);
    check_rb("R1", 32'h0);

    // R2 R3 R5: partial load must not reach the step in use
    load_step(a_val);
    check_rb("R5", a_val);
    for (int k = 0; k < 7; k++) write_slice(k, b_val[4*k +: 4]);
    check_rb("R2", a_val);
    write_slice(7, b_val[31:28]);
    check_rb("R3", b_val);

    // R4: enable pattern with a small step
    load_step(32'h0100_0000);
    @(negedge clk);
    pix_en = 1'b1; frame_lock = 1'b1; frame_sof = 1'b1;
    post_edge();
    check("R8", phase_out, 0);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      frame_sof = 1'b0; frame_lock = 1'b0;
      pix_en = pat[c];
      if (pat[c]) ups++;
      post_edge();
      check("R4", phase_out, 10'((ups * 4) % 1024));
    end

    // R8: without lock the frame pulse is ignored
    @(negedge clk);
    pix_en = 1'b1;
    post_edge();
    p0 = phase_out;
    @(negedge clk);
    frame_sof = 1'b1;
    post_edge();
    check("R8", phase_out, 10'(p0 + 10'd4));
    @(negedge clk);
    frame_sof = 1'b0;

    // R3 R8: clear and step commit on the same edge
    for (int k = 0; k < 7; k++) write_slice(k, b_val[4*k +: 4]);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = b_val[31:28];
    frame_lock = 1'b1; frame_sof = 1'b1;
    post_edge();
    check("R8", phase_out, 0);
    @(negedge clk);
    wr_en = 1'b0; frame_sof = 1'b0; frame_lock = 1'b0;
    post_edge();
    check("R3", phase_out, b_val[31:22]);

    // Sweep of delay, standard and step
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int s = 0; s < 2; s++)
          burst_run(dl[i], s[0], sl[j]);

    // R9: a new sync edge restarts the delay
    load_step(32'h4000_0000);
    @(negedge clk);
    std_pal = 1'b0; burst_dly = 8'd2; frame_lock = 1'b1; frame_sof = 1'b1; hsync = 1'b1;
    for (int m = 0; m < 5; m++) begin
      post_edge();
      if (m == 3) check("R6", burst_en, 1);
      @(negedge clk);
      frame_sof = 1'b0;
      if (m == 4) hsync = 1'b0;
    end
    post_edge();
    @(negedge clk);
    hsync = 1'b1;
    post_edge();
    check("R9", burst_en, 0);
    post_edge();
    post_edge();
    check("R9", burst_en, 0);
    post_edge();
    check("R9", burst_en, 1);
    @(negedge clk);
    hsync = 1'b0; frame_lock = 1'b0;
    repeat (60) @(negedge clk);
    check("R7", burst_en, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule